// File: doc/BRIEF.md
# Random Number Generator Register Bank

This block is the software-facing register file of a random number generator core. Software reaches it over a simple word-addressed bus. Each location is one 32-bit word, and a byte offset maps to bus word index offset/4. The block does not contain the entropy source, the conditioning logic or the deterministic generator. Finished 128-bit results reach it on a valid/ready port.

When the result buffer is empty, the block captures the offered result into four readable output words and raises a ready flag. It then holds off further results until software acknowledges. Software reads status and writes acknowledge at the same location. Software reads the four words and then writes 1 to bit 0 of that location, which frees the buffer for the next result.

The bank also holds the settings that drive the core:
- the generator enable,
- a noise-block count and a sample-cycle count, which are frozen while the generator runs,
- the oscillator enables,
- detune, alarm count, alarm mask and alarm stop words,
- an optional interrupt mask,
- a read-only revision word.

Top module: `rng_regbank`

## Requirements
- R1: After reset every register reads 0 except the revision word, the ready flag is 0, `res_ready` is 1, `irq` is 0 and `gen_en` is 0.
- R2: When the ready flag is 0 and `res_valid` is 1 at a clock edge, the 128-bit result is captured and the flag is 1 from the next cycle. Word k (index k, byte offset 4k, k=0..3) reads result bits 32k+31:32k.
- R3: While the ready flag is 1, `res_ready` is 0, offered results are not taken, and the output words keep their values.
- R4: A read of index 4 (byte 0x10) returns the ready flag in bit 0 and 0 in bits 31:1.
- R5: A write to index 4 with data bit 0 = 1 clears the ready flag. A write there with bit 0 = 0 has no effect.
- R6: Index 5 (byte 0x14) holds the generator enable in bit 10, which also drives `gen_en`. Its other bits read 0.
- R7: Index 6 (byte 0x18) holds the noise-block count in bits 7:0 and the sample-cycle count in bits 23:16, and drives `cfg_noise_blocks` and `cfg_sample_cycles`. A write to index 6 takes effect only while the enable is 0 and is ignored otherwise. Its other bits read 0.
- R8: Index 8 (byte 0x20) holds NUM_FRO oscillator enable bits, which drive `osc_enable`. Indices 7, 9, 10 and 11 (bytes 0x1C, 0x24, 0x28, 0x2C: alarm count, detune, alarm mask, alarm stop) are full 32-bit read/write words.
- R9: Index 31 (byte 0x7C) reads the constant {4'h0, major, minor, patch, 8'h00, 8'h4C}, and writes to it are ignored. The default version is 2.3.1, so the word is 0x0231004C.
- R10: Unmapped indices read 0. Writes to unmapped indices and to the output words change nothing.
- R11: With IRQ_MASK_EN=1, index 12 (byte 0x30) bit 0 is an interrupt mask and `irq` = flag AND mask. With IRQ_MASK_EN=0, `irq` = flag and index 12 is unmapped.
- R12: `bus_rdata` shows the addressed word one clock after `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| res_valid | input | 1 | Result offered by the core |
| res_data | input | 32*NUM_WORDS | Result value |
| res_ready | output | 1 | Buffer free, result will be taken |
| irq | output | 1 | Result-ready interrupt |
| gen_en | output | 1 | Generator enable |
| cfg_noise_blocks | output | 8 | Noise-block count |
| cfg_sample_cycles | output | 8 | Sample-cycle count |
| osc_enable | output | NUM_FRO | Oscillator enables |

## Verification
The bench builds the block with IRQ_MASK_EN=1 and otherwise default parameters: four result words, 24 oscillator enables and version 2.3.1. With a five-bit index space, the bench can sweep every one of the 32 locations after reset and again after a write of a distinct pattern. That sweep covers the unmapped holes, the read-only words and the masked fields. Enabling the interrupt mask brings the gating of `irq` into reach. A run of results, some offered while the buffer is full, exercises hold-off, acknowledge with either value of bit 0, and the configuration lock in both enable states.

// File: rtl/rng_regbank_pkg.sv
package rng_regbank_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  localparam logic [IDX_W-1:0] WI_STATUS  = 5'd4;
  localparam logic [IDX_W-1:0] WI_CTRL    = 5'd5;
  localparam logic [IDX_W-1:0] WI_CFG     = 5'd6;
  localparam logic [IDX_W-1:0] WI_ALMCNT  = 5'd7;
  localparam logic [IDX_W-1:0] WI_OSCEN   = 5'd8;
  localparam logic [IDX_W-1:0] WI_DETUNE  = 5'd9;
  localparam logic [IDX_W-1:0] WI_ALMMASK = 5'd10;
  localparam logic [IDX_W-1:0] WI_ALMSTOP = 5'd11;
  localparam logic [IDX_W-1:0] WI_IRQMASK = 5'd12;
  localparam logic [IDX_W-1:0] WI_REV     = 5'd31;

  localparam int CTRL_EN_BIT = 10;
  localparam logic [7:0] CORE_ID = 8'h4C;

  function automatic logic [DATA_W-1:0] rev_word(input logic [3:0] maj,
                                                 input logic [3:0] mnr,
                                                 input logic [3:0] pat);
    return {4'h0, maj, mnr, pat, 8'h00, CORE_ID};
  endfunction
endpackage

// File: rtl/rng_result_buf.sv
module rng_result_buf #(
  parameter int RES_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             ack,
  output logic             res_ready,
  output logic             flag,
  output logic [RES_W-1:0] words
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      words <= '0;
    end else if (res_valid && !flag) begin
      words <= res_data;
      flag  <= 1'b1;
    end else if (ack) begin
      flag <= 1'b0;
    end
  end

  assign res_ready = !flag;
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_regbank_pkg::*;
#(
  parameter int NUM_FRO     = 24,
  parameter bit IRQ_MASK_EN = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [IDX_W-1:0]   widx,
  input  logic [DATA_W-1:0]  wdata,
  output logic               gen_en,
  output logic [7:0]         cfg_nb,
  output logic [7:0]         cfg_sc,
  output logic [NUM_FRO-1:0] fro_en,
  output logic [DATA_W-1:0]  alm_cnt,
  output logic [DATA_W-1:0]  detune,
  output logic [DATA_W-1:0]  alm_mask,
  output logic [DATA_W-1:0]  alm_stop,
  output logic               irq_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en   <= 1'b0;
      cfg_nb   <= '0;
      cfg_sc   <= '0;
      fro_en   <= '0;
      alm_cnt  <= '0;
      detune   <= '0;
      alm_mask <= '0;
      alm_stop <= '0;
    end else if (wr) begin
      case (widx)
        WI_CTRL:    gen_en <= wdata[CTRL_EN_BIT];
        WI_CFG: if (!gen_en) begin
          cfg_nb <= wdata[7:0];
          cfg_sc <= wdata[23:16];
        end
        WI_OSCEN:   fro_en   <= wdata[NUM_FRO-1:0];
        WI_ALMCNT:  alm_cnt  <= wdata;
        WI_DETUNE:  detune   <= wdata;
        WI_ALMMASK: alm_mask <= wdata;
        WI_ALMSTOP: alm_stop <= wdata;
        default: ;
      endcase
    end
  end

  generate
    if (IRQ_MASK_EN) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst) irq_mask <= 1'b0;
        else if (wr && widx == WI_IRQMASK) irq_mask <= wdata[0];
      end
    end else begin : g_nomask
      assign irq_mask = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rng_read_mux.sv
module rng_read_mux
  import rng_regbank_pkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int NUM_FRO     = 24,
  parameter bit IRQ_MASK_EN = 1'b0,
  parameter logic [DATA_W-1:0] REV = 32'h0
) (
  input  logic [IDX_W-1:0]            ridx,
  input  logic [DATA_W*NUM_WORDS-1:0] words,
  input  logic                        flag,
  input  logic                        gen_en,
  input  logic [7:0]                  cfg_nb,
  input  logic [7:0]                  cfg_sc,
  input  logic [NUM_FRO-1:0]          fro_en,
  input  logic [DATA_W-1:0]           alm_cnt,
  input  logic [DATA_W-1:0]           detune,
  input  logic [DATA_W-1:0]           alm_mask,
  input  logic [DATA_W-1:0]           alm_stop,
  input  logic                        irq_mask,
  output logic [DATA_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    case (ridx)
      WI_STATUS:  rdata[0] = flag;
      WI_CTRL:    rdata[CTRL_EN_BIT] = gen_en;
      WI_CFG:     rdata = {8'h00, cfg_sc, 8'h00, cfg_nb};
      WI_OSCEN:   rdata[NUM_FRO-1:0] = fro_en;
      WI_ALMCNT:  rdata = alm_cnt;
      WI_DETUNE:  rdata = detune;
      WI_ALMMASK: rdata = alm_mask;
      WI_ALMSTOP: rdata = alm_stop;
      WI_IRQMASK: rdata[0] = IRQ_MASK_EN && irq_mask;
      WI_REV:     rdata = REV;
      default: ;
    endcase
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (ridx == k[IDX_W-1:0]) rdata = words[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/rng_regbank.sv
module rng_regbank
  import rng_regbank_pkg::*;
#(
  parameter int NUM_WORDS   = 4,
  parameter int NUM_FRO     = 24,
  parameter bit IRQ_MASK_EN = 1'b0,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd3,
  parameter logic [3:0] REV_PATCH = 4'd1,
  localparam int RES_W = DATA_W * NUM_WORDS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [IDX_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_data,
  output logic               res_ready,
  output logic               irq,
  output logic               gen_en,
  output logic [7:0]         cfg_noise_blocks,
  output logic [7:0]         cfg_sample_cycles,
  output logic [NUM_FRO-1:0] osc_enable
);
  localparam logic [DATA_W-1:0] REV = rev_word(REV_MAJOR, REV_MINOR, REV_PATCH);

  logic              rdy_flag;
  logic [RES_W-1:0]  res_words;
  logic              ack;
  logic [DATA_W-1:0] alm_cnt, detune, alm_mask, alm_stop, rdata_next;
  logic              irq_mask;

  assign ack = bus_wr && bus_addr == WI_STATUS && bus_wdata[0];

  rng_result_buf #(.RES_W(RES_W)) u_buf (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .ack(ack), .res_ready(res_ready), .flag(rdy_flag), .words(res_words)
  );

  rng_ctrl_regs #(.NUM_FRO(NUM_FRO), .IRQ_MASK_EN(IRQ_MASK_EN)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .widx(bus_addr), .wdata(bus_wdata),
    .gen_en(gen_en), .cfg_nb(cfg_noise_blocks), .cfg_sc(cfg_sample_cycles),
    .fro_en(osc_enable), .alm_cnt(alm_cnt), .detune(detune),
    .alm_mask(alm_mask), .alm_stop(alm_stop), .irq_mask(irq_mask)
  );

  rng_read_mux #(.NUM_WORDS(NUM_WORDS), .NUM_FRO(NUM_FRO),
                 .IRQ_MASK_EN(IRQ_MASK_EN), .REV(REV)) u_mux (
    .ridx(bus_addr), .words(res_words), .flag(rdy_flag), .gen_en(gen_en),
    .cfg_nb(cfg_noise_blocks), .cfg_sc(cfg_sample_cycles), .fro_en(osc_enable),
    .alm_cnt(alm_cnt), .detune(detune), .alm_mask(alm_mask),
    .alm_stop(alm_stop), .irq_mask(irq_mask), .rdata(rdata_next)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_next;
  end

  assign irq = rdy_flag && irq_mask;
endmodule

// File: rtl/rng_regbank_chk.sv
module rng_regbank_chk
  import rng_regbank_pkg::*;
#(
  parameter int RES_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic             flag,
  input logic [RES_W-1:0] word_q,
  input logic             irq,
  input logic             gen_en,
  input logic [7:0]       cfg_nb,
  input logic [7:0]       cfg_sc,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_addr,
  input logic             wbit0
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ready |=> flag && word_q == $past(res_data));
  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    flag |-> !res_ready);
  // R3
  words_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    flag |=> $stable(word_q));
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == WI_STATUS && wbit0 && !(res_valid && res_ready) |=> !flag);
  // R7
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    gen_en |=> $stable(cfg_nb) && $stable(cfg_sc));
  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |-> !irq);
endmodule

bind rng_regbank rng_regbank_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .flag(rdy_flag), .word_q(res_words), .irq(irq),
  .gen_en(gen_en), .cfg_nb(cfg_noise_blocks), .cfg_sc(cfg_sample_cycles),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .wbit0(bus_wdata[0])
);

// File: tb/sim_rng_regbank.sv
module sim_rng_regbank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata;
  logic         res_valid = 1'b0, res_ready, irq, gen_en;
  logic [127:0] res_data = '0;
  logic [7:0]   cfg_nb, cfg_sc;
  logic [23:0]  osc_en;

  int n_chk = 0, n_fail = 0;

  // model state from the requirements
  logic        m_flag = 0, m_en = 0, m_mask = 0;
  logic [31:0] m_cfg = 0, m_fro = 0;
  logic [31:0] m_reg [0:31];
  logic [31:0] m_words [0:3];

  always #4 clk = ~clk;

  rng_regbank #(.IRQ_MASK_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .irq(irq), .gen_en(gen_en),
    .cfg_noise_blocks(cfg_nb), .cfg_sample_cycles(cfg_sc), .osc_enable(osc_en)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    if (i < 4) return "R2";
    case (i)
      4: return "R4";
      5: return "R6";
      6: return "R7";
      7, 8, 9, 10, 11: return "R8";
      12: return "R11";
      31: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] m_read(int i);
    if (i < 4) return m_words[i];
    case (i)
      4: return {31'b0, m_flag};
      5: return {21'b0, m_en, 10'b0};
      6: return m_cfg;
      8: return m_fro;
      7, 9, 10, 11: return m_reg[i];
      12: return {31'b0, m_mask};
      31: return 32'h0231_004C;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(int i, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = i[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (i)
      4: if (d[0]) m_flag = 1'b0;
      5: m_en = d[10];
      6: if (!m_en) m_cfg = d & 32'h00FF_00FF;
      8: m_fro = d & 32'h00FF_FFFF;
      7, 9, 10, 11: m_reg[i] = d;
      12: m_mask = d[0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(int i);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = i[4:0];
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag_of(i), bus_rdata, m_read(i));
  endtask

  task automatic push(logic [127:0] d);
    @(negedge clk);
    res_valid = 1'b1; res_data = d;
    check(m_flag ? "R3 res_ready" : "R2 res_ready", {31'b0, res_ready}, {31'b0, !m_flag});
    @(negedge clk);
    res_valid = 1'b0;
    if (!m_flag) begin
      for (int j = 0; j < 4; j++) m_words[j] = d[j*32 +: 32];
      m_flag = 1'b1;
    end
  endtask

  task automatic port_chk();
    check("R6 gen_en", {31'b0, gen_en}, {31'b0, m_en});
    check("R7 cfg pins", {8'h0, cfg_sc, 8'h0, cfg_nb}, m_cfg);
    check("R8 osc pins", {8'h0, osc_en}, m_fro);
    check("R11 irq", {31'b0, irq}, {31'b0, m_flag & m_mask});
  endtask

  function automatic logic [127:0] pattern(int k);
    logic [127:0] r;
    for (int j = 0; j < 4; j++) r[j*32 +: 32] = (k * 32'h9E37_79B9) ^ (j * 32'h0100_0193) ^ 32'h5A00_0000;
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int j = 0; j < 4; j++) m_words[j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 res_ready", {31'b0, res_ready}, 32'd1);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 gen_en", {31'b0, gen_en}, 32'd0);
    for (int i = 0; i < 32; i++) rd_chk(i);
    // R12: data holds after the read strobe drops
    rd_chk(31);
    repeat (2) @(negedge clk);
    check("R12 hold", bus_rdata, 32'h0231_004C);
    // full-map write/read sweep (R8, R9, R10)
    for (int i = 0; i < 32; i++) wr(i, 32'hDEAD_BEEF ^ (i * 32'h0101_0101));
    for (int i = 0; i < 32; i++) rd_chk(i);
    port_chk();
    // R7 lock: enable then attempt config change
    wr(5, 32'h0000_0400);
    wr(6, 32'h1234_5678);
    rd_chk(6); port_chk();
    wr(5, 32'hFFFF_FBFF);
    wr(6, 32'hABCD_EF01);
    rd_chk(6); rd_chk(5); port_chk();
    // results, hold-off, acknowledge (R2 R3 R4 R5 R11)
    wr(12, 32'h1);
    for (int k = 1; k <= 6; k++) begin
      push(pattern(k));
      port_chk();
      rd_chk(4);
      push(pattern(k + 100));
      for (int j = 0; j < 4; j++) rd_chk(j);
      wr(0, 32'hFFFF_FFFF);
      rd_chk(0);
      wr(4, 32'hFFFF_FFFE);
      rd_chk(4);
      if (k == 3) wr(12, 32'h0);
      port_chk();
      wr(4, 32'h1);
      rd_chk(4); port_chk();
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule